// File: doc/BRIEF.md
# Per-Stream Translation Configuration Register File

This block is the software-visible configuration store of a small I/O address translation unit that serves a fixed set of DMA streams. Each stream owns a 32-bit mode word and a set of table base registers. Each table base carries a valid flag in its top bit and a page-frame number in its low bits. Beside these sit a byte-per-stream remap table, two read-only capability words and a sticky lock bit. When software sets the lock, all stream configuration is frozen until the next reset.

Software reaches the block over a simple single-cycle 32-bit bus. A write is taken on the rising clock edge while the write strobe is high. Read data follows the address combinationally. The block also decodes each stream's registers into a 2-bit mode that the translation datapath uses: translate, bypass or blocked. It presents the remap bytes as a flat vector. Page walking, TLB storage and invalidation commands live elsewhere.

Top module: `iotu_stream_regs`

## Requirements
- R1: After reset every mode word and table base reads 0, the lock reads 0, and the remap words at 0x80..0x8C read 0x03020100, 0x07060504, 0x0b0a0908, 0x0f0e0d0c. Stream s's remap byte equals s.
- R2: The mode word of stream s is at byte offset 0x100 + 4*s. All 32 bits are written and read back unchanged.
- R3: Table base i of stream s is at 0x200 + 16*s + 4*i. All 32 bits are stored. Bit 31 is its valid flag.
- R4: Offset 0x00 reads the page-size log2 parameter in bits 27:24 and zero elsewhere (0x0E000000 by default). Offset 0x04 reads the bypass capability in bit 0. Writes to both offsets have no effect.
- R5: The remap table is four words at 0x80. Stream s occupies byte s%4 (bits 8*(s%4)+7 : 8*(s%4)) of word 0x80 + 4*(s/4). It is writable, and stream_remap_o[8*s +: 8] presents byte s.
- R6: Bit 15 of offset 0x60 is the lock. Writing 1 sets it. Writing 0 never clears it; only reset clears it. The offset reads the lock in bit 15 and zero elsewhere.
- R7: While the lock is set, writes to mode words, table bases and remap words are ignored, and reads return the stored values.
- R8: stream_mode_o[2*s +: 2] is 2'b01 (translate) when bit 7 of the stream's mode word is set and bit 31 of its table base 0 is set. This takes priority over bypass and does not depend on the capability.
- R9: When translate does not apply, the mode is 2'b10 (bypass) if bit 8 or bit 12 of the mode word is set and the bypass capability is 1. With capability 0 such a stream is blocked.
- R10: In every other case the mode is 2'b00 (blocked). In particular, a zero mode word blocks the stream, and so does bit 7 with an invalid base 0.
- R11: Reads of any unmapped or non-word-aligned offset return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, taken at the rising edge |
| bus_addr_i | input | 12 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| stream_mode_o | output | 2*NUM_STREAMS | Decoded mode per stream: 00 blocked, 01 translate, 10 bypass |
| stream_remap_o | output | 8*NUM_STREAMS | Remap byte per stream |

## Verification
The assertions watch the properties that hold on every cycle. The lock never falls once raised. While the lock is high, the mode words and remap words cannot change. A zero mode word always yields a blocked stream. A translate mode is only ever reported with bit 7 set and a valid base 0. Unmapped reads always return zero. Address placement and the byte order of the remap table can only be shown by the bench's write-then-read scenarios. So can the translate-over-bypass priority, the effect of a missing bypass capability (shown on a second instance), and the lock being cleared by reset.

// File: rtl/iotu_pkg.sv
package iotu_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'b00,
    MODE_XLATE  = 2'b01,
    MODE_BYPASS = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_PARAM0,
    HIT_PARAM1,
    HIT_CFG,
    HIT_REMAP,
    HIT_CTRL,
    HIT_BASE
  } hit_e;

  localparam int OFS_PARAM0 = 'h000;
  localparam int OFS_PARAM1 = 'h004;
  localparam int OFS_CFG    = 'h060;
  localparam int OFS_REMAP  = 'h080;
  localparam int OFS_CTRL   = 'h100;
  localparam int OFS_BASE   = 'h200;
  localparam int BASE_STRIDE = 16;

  localparam int BIT_XLATE  = 7;
  localparam int BIT_BYP0   = 8;
  localparam int BIT_BYP1   = 12;
  localparam int BIT_VALID  = 31;
  localparam int BIT_LOCK   = 15;

  // Mode selection: translate wins over bypass, everything else blocks.
  function automatic mode_e pick_mode(input logic [31:0] ctrl,
                                      input logic base0_valid,
                                      input logic cap);
    if (ctrl[BIT_XLATE] && base0_valid)
      return MODE_XLATE;
    else if ((ctrl[BIT_BYP0] || ctrl[BIT_BYP1]) && cap)
      return MODE_BYPASS;
    else
      return MODE_BLOCK;
  endfunction

  // Reset content of remap byte b: identity mapping.
  function automatic logic [7:0] identity_byte(input int b);
    return 8'(b);
  endfunction

endpackage

// File: rtl/iotu_addr_decode.sv
module iotu_addr_decode
  import iotu_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int NUM_BASES   = 4,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int REMAP_WORDS = (NUM_STREAMS + 3) / 4,
  localparam int WW = (REMAP_WORDS > 1) ? $clog2(REMAP_WORDS) : 1
) (
  input  logic [11:0]   addr_i,
  output hit_e          hit_o,
  output logic [SW-1:0] stream_o,
  output logic [1:0]    idx_o,
  output logic [WW-1:0] word_o
);

  logic [31:0] a;
  assign a = {20'd0, addr_i};

  always_comb begin
    hit_o    = HIT_NONE;
    stream_o = '0;
    idx_o    = '0;
    word_o   = '0;
    if (a == 32'(OFS_PARAM0)) hit_o = HIT_PARAM0;
    if (a == 32'(OFS_PARAM1)) hit_o = HIT_PARAM1;
    if (a == 32'(OFS_CFG))    hit_o = HIT_CFG;
    for (int w = 0; w < REMAP_WORDS; w++) begin
      if (a == 32'(OFS_REMAP + 4 * w)) begin
        hit_o  = HIT_REMAP;
        word_o = WW'(w);
      end
    end
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (a == 32'(OFS_CTRL + 4 * s)) begin
        hit_o    = HIT_CTRL;
        stream_o = SW'(s);
      end
      for (int i = 0; i < NUM_BASES; i++) begin
        if (a == 32'(OFS_BASE + BASE_STRIDE * s + 4 * i)) begin
          hit_o    = HIT_BASE;
          stream_o = SW'(s);
          idx_o    = 2'(i);
        end
      end
    end
  end

endmodule

// File: rtl/iotu_stream_slot.sv
module iotu_stream_slot
  import iotu_pkg::*;
#(
  parameter int NUM_BASES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lock_i,
  input  logic                   cap_i,
  input  logic                   ctrl_we_i,
  input  logic                   base_we_i,
  input  logic [1:0]             base_idx_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            ctrl_o,
  output logic [NUM_BASES*32-1:0] bases_o,
  output mode_e                  mode_o
);

  logic [31:0] ctrl_q;
  logic [31:0] base_q [NUM_BASES];
  logic        ctrl_upd;

  assign ctrl_upd = ctrl_we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (ctrl_upd) ctrl_q <= wdata_i;
  end

  for (genvar i = 0; i < NUM_BASES; i++) begin : g_base
    logic base_upd;
    assign base_upd = base_we_i && !lock_i && (base_idx_i == 2'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       base_q[i] <= '0;
      else if (base_upd) base_q[i] <= wdata_i;
    end
    assign bases_o[32*i +: 32] = base_q[i];
  end

  assign ctrl_o = ctrl_q;
  assign mode_o = pick_mode(ctrl_q, base_q[0][BIT_VALID], cap_i);

  AST_CTRL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(ctrl_q)); // R7
  AST_BASE0_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(base_q[0])); // R7
  AST_ZERO_CTRL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 32'd0) |-> (mode_o == MODE_BLOCK)); // R10
  AST_XLATE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_XLATE) |-> (ctrl_q[BIT_XLATE] && base_q[0][BIT_VALID])); // R8

endmodule

// File: rtl/iotu_remap_table.sv
module iotu_remap_table
  import iotu_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  localparam int REMAP_WORDS = (NUM_STREAMS + 3) / 4,
  localparam int WW = (REMAP_WORDS > 1) ? $clog2(REMAP_WORDS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lock_i,
  input  logic                       we_i,
  input  logic [WW-1:0]              word_i,
  input  logic [31:0]                wdata_i,
  output logic [REMAP_WORDS*32-1:0]  words_o,
  output logic [NUM_STREAMS*8-1:0]   map_o
);

  logic [REMAP_WORDS*32-1:0] tbl_q;

  for (genvar w = 0; w < REMAP_WORDS; w++) begin : g_word
    logic upd;
    assign upd = we_i && !lock_i && (word_i == WW'(w));
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  tbl_q[32*w + 8*b +: 8] <= identity_byte(4 * w + b);
        else if (upd) tbl_q[32*w + 8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign words_o = tbl_q;
  assign map_o   = tbl_q[NUM_STREAMS*8-1:0];

  AST_REMAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(tbl_q)); // R7

endmodule

// File: rtl/iotu_stream_regs.sv
module iotu_stream_regs
  import iotu_pkg::*;
#(
  parameter int   NUM_STREAMS = 16,
  parameter int   NUM_BASES   = 4,
  parameter int   PAGE_LOG2   = 14,
  parameter logic BYPASS_CAP  = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [11:0]              bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  output logic [31:0]              bus_rdata_o,
  output logic [2*NUM_STREAMS-1:0] stream_mode_o,
  output logic [8*NUM_STREAMS-1:0] stream_remap_o
);

  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
  localparam int REMAP_WORDS = (NUM_STREAMS + 3) / 4;
  localparam int WW = (REMAP_WORDS > 1) ? $clog2(REMAP_WORDS) : 1;
  localparam logic [3:0] PG = 4'(PAGE_LOG2);

  hit_e          hit;
  logic [SW-1:0] hit_stream;
  logic [1:0]    hit_idx;
  logic [WW-1:0] hit_word;

  iotu_addr_decode #(
    .NUM_STREAMS(NUM_STREAMS),
    .NUM_BASES  (NUM_BASES)
  ) u_dec (
    .addr_i  (bus_addr_i),
    .hit_o   (hit),
    .stream_o(hit_stream),
    .idx_o   (hit_idx),
    .word_o  (hit_word)
  );

  // Lock: set-only, cleared by reset alone.
  logic lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (bus_we_i && hit == HIT_CFG && bus_wdata_i[BIT_LOCK]) lock_q <= 1'b1;
  end

  logic [31:0]            ctrl_w  [NUM_STREAMS];
  logic [NUM_BASES*32-1:0] bases_w [NUM_STREAMS];

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic  ctrl_we, base_we;
    mode_e mode;
    assign ctrl_we = bus_we_i && hit == HIT_CTRL && hit_stream == SW'(s);
    assign base_we = bus_we_i && hit == HIT_BASE && hit_stream == SW'(s);
    iotu_stream_slot #(.NUM_BASES(NUM_BASES)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_i    (lock_q),
      .cap_i     (BYPASS_CAP),
      .ctrl_we_i (ctrl_we),
      .base_we_i (base_we),
      .base_idx_i(hit_idx),
      .wdata_i   (bus_wdata_i),
      .ctrl_o    (ctrl_w[s]),
      .bases_o   (bases_w[s]),
      .mode_o    (mode)
    );
    assign stream_mode_o[2*s +: 2] = mode;
  end

  logic [REMAP_WORDS*32-1:0] remap_words;
  logic                      remap_we;
  assign remap_we = bus_we_i && hit == HIT_REMAP;

  iotu_remap_table #(.NUM_STREAMS(NUM_STREAMS)) u_remap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_q),
    .we_i   (remap_we),
    .word_i (hit_word),
    .wdata_i(bus_wdata_i),
    .words_o(remap_words),
    .map_o  (stream_remap_o)
  );

  always_comb begin
    unique case (hit)
      HIT_PARAM0: bus_rdata_o = {4'd0, PG, 24'd0};
      HIT_PARAM1: bus_rdata_o = {31'd0, BYPASS_CAP};
      HIT_CFG:    bus_rdata_o = 32'(lock_q) << BIT_LOCK;
      HIT_REMAP:  bus_rdata_o = remap_words[32*int'(hit_word) +: 32];
      HIT_CTRL:   bus_rdata_o = ctrl_w[hit_stream];
      HIT_BASE:   bus_rdata_o = bases_w[hit_stream][32*int'(hit_idx) +: 32];
      default:    bus_rdata_o = 32'd0;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == HIT_NONE) |-> (bus_rdata_o == 32'd0)); // R11
  AST_PAGE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == HIT_PARAM0) |-> (bus_rdata_o[27:24] == PG)); // R4

endmodule

// File: tb/iotu_stream_regs_tb.sv
module iotu_stream_regs_tb_top;

  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nc;
  logic [2*NS-1:0] mode, mode_nc;
  logic [8*NS-1:0] remap, remap_nc;

  int nchecks = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  iotu_stream_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .stream_mode_o(mode),
    .stream_remap_o(remap)
  );

  // Second instance without bypass capability, sharing the same bus writes.
  iotu_stream_regs #(.BYPASS_CAP(1'b0)) dut_nocap_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_nc), .stream_mode_o(mode_nc),
    .stream_remap_o(remap_nc)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0E00_0000, 4'd4},
    '{1'b0, 12'h004, 32'h0000_0001, 4'd4},
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 4'd4},
    '{1'b0, 12'h000, 32'h0E00_0000, 4'd4},
    '{1'b1, 12'h004, 32'h0000_0000, 4'd4},
    '{1'b0, 12'h004, 32'h0000_0001, 4'd4},
    '{1'b1, 12'h104, 32'h0000_0080, 4'd2},
    '{1'b0, 12'h104, 32'h0000_0080, 4'd2},
    '{1'b1, 12'h13C, 32'hDEAD_BEEF, 4'd2},
    '{1'b0, 12'h13C, 32'hDEAD_BEEF, 4'd2},
    '{1'b1, 12'h214, 32'h8001_2345, 4'd3},
    '{1'b0, 12'h214, 32'h8001_2345, 4'd3},
    '{1'b1, 12'h2FC, 32'h8000_ABCD, 4'd3},
    '{1'b0, 12'h2FC, 32'h8000_ABCD, 4'd3},
    '{1'b0, 12'h210, 32'h0000_0000, 4'd3},
    '{1'b0, 12'h080, 32'h0302_0100, 4'd5},
    '{1'b1, 12'h08C, 32'h1122_3344, 4'd5},
    '{1'b0, 12'h08C, 32'h1122_3344, 4'd5},
    '{1'b1, 12'h0A0, 32'h1234_5678, 4'd11},
    '{1'b0, 12'h0A0, 32'h0000_0000, 4'd11},
    '{1'b0, 12'h300, 32'h0000_0000, 4'd11},
    '{1'b0, 12'h106, 32'h0000_0000, 4'd11},
    '{1'b0, 12'h060, 32'h0000_0000, 4'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic mode_chk(input string req, input int s, input logic [1:0] exp, input bit nocap);
    #1;
    chk(req, 32'(nocap ? mode_nc[2*s +: 2] : mode[2*s +: 2]), 32'(exp));
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd("R1", 12'h104, 32'h0);
    bus_rd("R1", 12'h200, 32'h0);
    bus_rd("R1", 12'h060, 32'h0);
    bus_rd("R1", 12'h08C, 32'h0F0E_0D0C);
    chk("R1", 32'(remap[8*9 +: 8]), 32'h09);
    mode_chk("R1", 0, 2'b00, 1'b0);

    // Table-driven register placement checks (R2 R3 R4 R5 R11 R6)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
      else bus_rd($sformatf("R%0d", VECS[i].req), VECS[i].a, VECS[i].d);
    end
    addr = 12'h004; #1;
    chk("R4", rdata_nc, 32'h0);
    // R5 byte placement on the remap output
    chk("R5", 32'(remap[8*12 +: 8]), 32'h44);
    chk("R5", 32'(remap[8*15 +: 8]), 32'h11);
    chk("R5", 32'(remap[8*7 +: 8]), 32'h07);

    // R8 translate needs bit 7 and a valid base 0
    bus_wr(12'h108, 32'h0000_0080);
    mode_chk("R8", 2, 2'b00, 1'b0);
    bus_wr(12'h220, 32'h8000_0010);
    mode_chk("R8", 2, 2'b01, 1'b0);
    mode_chk("R8", 2, 2'b01, 1'b1);
    bus_wr(12'h220, 32'h0000_0010);
    mode_chk("R10", 2, 2'b00, 1'b0);
    bus_wr(12'h220, 32'h8000_0010);
    mode_chk("R8", 2, 2'b01, 1'b0);

    // R9 bypass via either bit, gated by capability
    bus_wr(12'h10C, 32'h0000_0100);
    mode_chk("R9", 3, 2'b10, 1'b0);
    mode_chk("R9", 3, 2'b00, 1'b1);
    bus_wr(12'h10C, 32'h0000_1000);
    mode_chk("R9", 3, 2'b10, 1'b0);
    bus_wr(12'h110, 32'h0000_1080);
    mode_chk("R9", 4, 2'b10, 1'b0);
    bus_wr(12'h240, 32'h8000_0000);
    mode_chk("R8", 4, 2'b01, 1'b0);

    // R10 blocked cases
    bus_wr(12'h10C, 32'h0000_0000);
    mode_chk("R10", 3, 2'b00, 1'b0);
    mode_chk("R10", 1, 2'b00, 1'b0);

    // R6 lock set-only, R7 frozen while locked
    bus_wr(12'h060, 32'h0000_8000);
    bus_rd("R6", 12'h060, 32'h0000_8000);
    bus_wr(12'h060, 32'h0000_0000);
    bus_rd("R6", 12'h060, 32'h0000_8000);
    bus_wr(12'h104, 32'hFFFF_FFFF);
    bus_rd("R7", 12'h104, 32'h0000_0080);
    bus_wr(12'h214, 32'h0000_0000);
    bus_rd("R7", 12'h214, 32'h8001_2345);
    bus_wr(12'h08C, 32'h0000_0000);
    bus_rd("R7", 12'h08C, 32'h1122_3344);
    bus_wr(12'h220, 32'h0000_0000);
    mode_chk("R7", 2, 2'b01, 1'b0);

    // R1 reset clears everything including the lock
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    bus_rd("R1", 12'h060, 32'h0);
    bus_rd("R1", 12'h104, 32'h0);
    bus_rd("R1", 12'h214, 32'h0);
    bus_rd("R1", 12'h08C, 32'h0F0E_0D0C);
    mode_chk("R1", 2, 2'b00, 1'b0);
    bus_wr(12'h104, 32'h0000_0005);
    bus_rd("R6", 12'h104, 32'h0000_0005);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule